// File: doc/BRIEF.md
# Configurable Digital I/O Channel

This block is one channel of a digital I/O function inside a controller driven by parameters. Both of its directions work on signed percentage words, held as 16-bit two's-complement integers in units of 0.01 % (so 30000 stands for +300.00 %). Software-side settings arrive on a simple register write port. A write to a percentage register that lies outside ±30000 is clamped to the nearer limit.

The output direction takes a stream of source values. Each value is optionally rectified and then compared with a programmable threshold. The result can be inverted. It drives an internal monitor bit and, only when the channel is enabled, the one-bit output pin. The source stream uses valid/ready. The channel never applies back-pressure outside reset: `src_ready` is high whenever reset is low. A beat transfers on any rising edge where valid and ready are both high. Between beats the channel keeps evaluating the last value it accepted, so a settings change is still reflected without new data.

The input direction passes a one-bit pin through a synchronizer. It then places one of two programmable percentages, the high-level value or the low-level value, on its result bus. A companion bit reads that result as a logic level: zero is low and anything else is high.

Top module: `dio_channel`

## Requirements
- R1: With the rectify control bit (register address 0, bit 2) set, the compared value is the magnitude of the source value, and the code -32768 gives +32767. With the bit clear, the source value is compared unchanged (bipolar).
- R2: The comparison state is HIGH only when the conditioned value is strictly greater than the threshold (register address 1). Equal values give LOW.
- R3: `mon` equals the comparison state, inverted when the invert bit (address 0, bit 1) is set. It is registered, so it reflects the source value and the settings that are current at a rising edge one edge later. With `src_valid` low, the last accepted source value is used.
- R4: `dout` equals the value registered into `mon` on the same edge, ANDed with the enable bit (address 0, bit 0). `dout` stays 0 while enable is 0.
- R5: `din` passes through two synchronizing flops. `in_result` is then registered as the high-level value (address 2) when the synchronized level is 1, and as the low-level value (address 3) when it is 0. A change on `din` reaches `in_result` on the third rising edge.
- R6: Writes to addresses 1, 2 and 3 are clamped to the range -30000..+30000. Writes to addresses 4 to 7 change nothing.
- R7: While `rst` is high at a rising edge, the channel sets enable, invert and rectify to 0, the threshold to 0, the high-level value to 1, the low-level value to 0, and `dout`, `mon`, `in_result`, `in_logic` and the synchronizer to 0.
- R8: `in_logic` is 1 exactly when the `in_result` registered on the same edge is nonzero, whatever its sign.
- R9: With the high-level value set to 0 and the low-level value set to 1, `in_logic` is the inverse of the synchronized `din`.
- R10: `src_ready` is high exactly when `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address: 0 control, 1 threshold, 2 high value, 3 low value |
| cfg_wdata | input | 16 | Write data (signed for addresses 1 to 3) |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Source beat accepted (high outside reset) |
| src_value | input | 16 | Signed source percentage |
| dout | output | 1 | Gated digital output |
| mon | output | 1 | Comparison result before gating |
| din | input | 1 | Asynchronous digital input pin |
| in_result | output | 16 | Selected signed percentage of the input direction |
| in_logic | output | 1 | `in_result` read as a logic level |

## Verification
The assertions assume that reset is held for at least one edge before any checked cycle, and that the register port is the only way settings change, so that stored percentages always lie within the clamp range. They also assume the synchronized input level is the only selector of `in_result`. The stimulus starts with several reset edges and drives every setting only through `cfg_we`. It includes writes far outside the range, writes to unused addresses and the code -32768, which together make the clamp and saturation paths do real work. `din` and `src_valid` are toggled at random so that both held and fresh source values are seen.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int PCT_W     = 16;
  localparam int PCT_LIMIT = 30000;
  localparam int ADDR_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_THR   = 3'd1,
    REG_HIVAL = 3'd2,
    REG_LOVAL = 3'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INV_BIT  = 1;
  localparam int CTRL_RECT_BIT = 2;

  typedef struct packed {
    logic rectify;
    logic invert;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/dio_cfg_regs.sv
module dio_cfg_regs
  import dio_pkg::*;
#(
  parameter int DATA_W = PCT_W,
  parameter int AW     = ADDR_W,
  parameter int LIMIT  = PCT_LIMIT,
  parameter int HI_RST = 1,
  parameter int LO_RST = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic signed [DATA_W-1:0] wdata,
  output ctrl_t                    ctrl_q,
  output logic signed [DATA_W-1:0] thr_q,
  output logic signed [DATA_W-1:0] hi_q,
  output logic signed [DATA_W-1:0] lo_q
);
  localparam logic signed [DATA_W-1:0] POS_LIM = DATA_W'(LIMIT);
  localparam logic signed [DATA_W-1:0] NEG_LIM = DATA_W'(-LIMIT);
  localparam logic signed [DATA_W-1:0] HI_INIT = DATA_W'(HI_RST);
  localparam logic signed [DATA_W-1:0] LO_INIT = DATA_W'(LO_RST);

  logic signed [DATA_W-1:0] clamped;
  ctrl_t                    ctrl_new;

  always_comb begin
    if (wdata > POS_LIM)      clamped = POS_LIM;
    else if (wdata < NEG_LIM) clamped = NEG_LIM;
    else                      clamped = wdata;
  end

  always_comb begin
    ctrl_new.enable  = wdata[CTRL_EN_BIT];
    ctrl_new.invert  = wdata[CTRL_INV_BIT];
    ctrl_new.rectify = wdata[CTRL_RECT_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      thr_q  <= '0;
      hi_q   <= HI_INIT;
      lo_q   <= LO_INIT;
    end else if (we) begin
      case (addr)
        REG_CTRL:  ctrl_q <= ctrl_new;
        REG_THR:   thr_q  <= clamped;
        REG_HIVAL: hi_q   <= clamped;
        REG_LOVAL: lo_q   <= clamped;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dio_out_path.sv
module dio_out_path
  import dio_pkg::*;
#(
  parameter int DATA_W = PCT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] value,
  input  ctrl_t                    ctrl,
  input  logic signed [DATA_W-1:0] thr,
  output logic                     mon,
  output logic                     dout
);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [DATA_W-1:0] held;
  logic signed [DATA_W-1:0] live;
  logic signed [DATA_W-1:0] mag;
  logic signed [DATA_W-1:0] cond;
  logic                     above;
  logic                     state;

  // Pick the fresh beat if one transfers, else the last accepted one.
  assign live = take ? value : held;

  // Saturating magnitude.
  always_comb begin
    if (live == MOST_NEG)  mag = MOST_POS;
    else if (live < 0)     mag = -live;
    else                   mag = live;
  end

  assign cond  = ctrl.rectify ? mag : live;
  assign above = cond > thr;
  assign state = above ^ ctrl.invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      mon  <= 1'b0;
      dout <= 1'b0;
    end else begin
      if (take) held <= value;
      mon  <= state;
      dout <= state & ctrl.enable;
    end
  end
endmodule

// File: rtl/dio_in_path.sv
module dio_in_path
  import dio_pkg::*;
#(
  parameter int DATA_W = PCT_W,
  parameter int STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     din,
  input  logic signed [DATA_W-1:0] hi,
  input  logic signed [DATA_W-1:0] lo,
  output logic signed [DATA_W-1:0] result,
  output logic                     level
);
  logic                     din_s;
  logic signed [DATA_W-1:0] pick;

  dio_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (din_s)
  );

  assign pick = din_s ? hi : lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      level  <= 1'b0;
    end else begin
      result <= pick;
      level  <= |pick;
    end
  end
endmodule

// File: rtl/dio_channel.sv
module dio_channel
  import dio_pkg::*;
#(
  parameter int DATA_W      = PCT_W,
  parameter int AW          = ADDR_W,
  parameter int LIMIT       = PCT_LIMIT,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_value,
  output logic              dout,
  output logic              mon,
  input  logic              din,
  output logic [DATA_W-1:0] in_result,
  output logic              in_logic
);
  ctrl_t                    ctrl_q;
  logic signed [DATA_W-1:0] thr_q;
  logic signed [DATA_W-1:0] hi_q;
  logic signed [DATA_W-1:0] lo_q;
  logic signed [DATA_W-1:0] res_s;
  logic                     take;
  logic                     en_w;

  assign src_ready = ~rst;
  assign take      = src_valid & src_ready;
  assign en_w      = ctrl_q.enable;

  dio_cfg_regs #(
    .DATA_W (DATA_W),
    .AW     (AW),
    .LIMIT  (LIMIT)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  ($signed(cfg_wdata)),
    .ctrl_q (ctrl_q),
    .thr_q  (thr_q),
    .hi_q   (hi_q),
    .lo_q   (lo_q)
  );

  dio_out_path #(.DATA_W(DATA_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .value ($signed(src_value)),
    .ctrl  (ctrl_q),
    .thr   (thr_q),
    .mon   (mon),
    .dout  (dout)
  );

  dio_in_path #(
    .DATA_W (DATA_W),
    .STAGES (SYNC_STAGES)
  ) u_in (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .hi     (hi_q),
    .lo     (lo_q),
    .result (res_s),
    .level  (in_logic)
  );

  assign in_result = res_s;
endmodule

// File: rtl/dio_channel_sva.sv
module dio_channel_sva #(
  parameter int DATA_W = 16,
  parameter int LIMIT  = 30000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     dout,
  input logic                     mon,
  input logic                     en_q,
  input logic [DATA_W-1:0]        in_result,
  input logic                     in_logic,
  input logic signed [DATA_W-1:0] thr_q,
  input logic signed [DATA_W-1:0] hi_q,
  input logic signed [DATA_W-1:0] lo_q
);
  // R4: a cleared enable keeps the pin low on the next edge
  p_gate_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_q)) |-> !dout);

  // R4: the pin is never high while the monitor is low
  p_pin_implies_mon_r4: assert property (@(posedge clk) disable iff (rst)
    dout |-> mon);

  // R5: the result is one of the two stored values of the previous cycle
  p_pick_source_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (in_result == $past(hi_q) || in_result == $past(lo_q)));

  // R8: level bit agrees with the registered result
  p_level_zero_r8: assert property (@(posedge clk) disable iff (rst)
    in_logic == (in_result != '0));

  // R6: stored percentages stay inside the clamp range
  p_range_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hi_q <= LIMIT && hi_q >= -LIMIT && lo_q <= LIMIT && lo_q >= -LIMIT &&
     thr_q <= LIMIT && thr_q >= -LIMIT));
endmodule

bind dio_channel dio_channel_sva #(.DATA_W(DATA_W), .LIMIT(LIMIT)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .dout      (dout),
  .mon       (mon),
  .en_q      (en_w),
  .in_result (in_result),
  .in_logic  (in_logic),
  .thr_q     (thr_q),
  .hi_q      (hi_q),
  .lo_q      (lo_q)
);

// File: tb/dio_channel_bench.sv
`timescale 1ns/1ps
module dio_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [15:0] src_value = '0;
  logic        dout, mon, din = 1'b0, in_logic;
  logic [15:0] in_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string phase = "R7";

  always #5 clk = ~clk;

  dio_channel u_dio_channel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_valid(src_valid), .src_ready(src_ready),
    .src_value(src_value), .dout(dout), .mon(mon), .din(din),
    .in_result(in_result), .in_logic(in_logic)
  );

  // Behavioural reference state
  int m_en, m_inv, m_rect, m_thr, m_hi, m_lo, m_hold;
  int m_s1, m_s2, m_mon, m_dout, m_res, m_lvl;

  function automatic int clampv(int v);
    if (v > 30000) return 30000;
    if (v < -30000) return -30000;
    return v;
  endfunction

  function automatic int mag(int v);
    if (v == -32768) return 32767;
    return (v < 0) ? -v : v;
  endfunction

  task automatic model_reset();
    m_en = 0; m_inv = 0; m_rect = 0; m_thr = 0; m_hi = 1; m_lo = 0;
    m_hold = 0; m_s1 = 0; m_s2 = 0; m_mon = 0; m_dout = 0; m_res = 0; m_lvl = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      int cur, c, st, wv;
      cur = src_valid ? int'($signed(src_value)) : m_hold;
      c = m_rect ? mag(cur) : cur;
      st = ((c > m_thr) ? 1 : 0) ^ m_inv;
      m_mon = st;
      m_dout = st & m_en;
      if (src_valid) m_hold = cur;
      m_res = m_s2 ? m_hi : m_lo;
      m_lvl = (m_res != 0) ? 1 : 0;
      m_s2 = m_s1;
      m_s1 = din;
      if (cfg_we) begin
        wv = int'($signed(cfg_wdata));
        case (cfg_addr)
          3'd0: begin m_en = cfg_wdata[0]; m_inv = cfg_wdata[1]; m_rect = cfg_wdata[2]; end
          3'd1: m_thr = clampv(wv);
          3'd2: m_hi = clampv(wv);
          3'd3: m_lo = clampv(wv);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", what, phase, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R3 mon", int'(mon), m_mon);
      check("R4 dout", int'(dout), m_dout);
      check("R5 in_result", int'($signed(in_result)), m_res);
      check("R8 in_logic", int'(in_logic), m_lvl);
      check("R10 src_ready", int'(src_ready), rst ? 0 : 1);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic send(int v);
    src_valid = 1'b1; src_value = 16'(v);
    step();
    src_valid = 1'b0;
  endtask

  initial begin
    step(4);
    // R7: reset state observed at the ports
    check("R7 reset mon", int'(mon), 0);
    check("R7 reset dout", int'(dout), 0);
    check("R7 reset in_result", int'(in_result), 0);
    rst = 1'b0;
    din = 1'b1;
    step(4);
    phase = "R7";
    check("R7 default high value", int'($signed(in_result)), 1);

    // R2: strict comparison, bipolar
    phase = "R2";
    wr(0, 1); wr(1, 500);
    send(500); step(2);
    check("R2 equal is low", int'(mon), 0);
    send(501); step(2);
    check("R2 above is high", int'(mon), 1);
    check("R4 enabled pin", int'(dout), 1);

    // R1: rectify with negative and most negative codes
    phase = "R1";
    send(-800); step(2);
    check("R1 bipolar negative low", int'(mon), 0);
    wr(0, 5); step(2);
    check("R1 rectified negative high", int'(mon), 1);
    wr(1, 30000); send(-32768); step(2);
    check("R1 most negative saturates", int'(mon), 1);

    // R3: invert and held source
    phase = "R3";
    wr(0, 7); step(3);
    check("R3 inverted held value", int'(mon), 0);
    wr(0, 2); step(2);
    check("R4 disabled pin", int'(dout), 0);

    // R6: clamping and ignored addresses
    phase = "R6";
    wr(2, 31000); step(3);
    check("R6 high value clamped", int'($signed(in_result)), 30000);
    wr(6, 123); wr(7, -5); step(3);
    check("R6 unused address ignored", int'($signed(in_result)), 30000);
    wr(3, -31000); din = 1'b0; step(4);
    check("R6 low value clamped", int'($signed(in_result)), -30000);
    check("R8 negative is high", int'(in_logic), 1);

    // R9: logic inversion through value choice
    phase = "R9";
    wr(2, 0); wr(3, 1); step(4);
    check("R9 low input gives high", int'(in_logic), 1);
    din = 1'b1; step(4);
    check("R9 high input gives low", int'(in_logic), 0);

    // R5: random traffic on every path
    phase = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      din = $urandom_range(0, 1);
      src_valid = ($urandom_range(0, 2) != 0);
      src_value = ($urandom_range(0, 15) == 0) ? 16'h8000 : 16'($urandom);
      cfg_we = (r < 3);
      cfg_addr = 3'($urandom_range(0, 7));
      cfg_wdata = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 7))
                                              : 16'($signed($urandom_range(0, 80000)) - 40000);
      if (i == 1500) rst = 1'b1;
      if (i == 1503) rst = 1'b0;
      step();
    end
    cfg_we = 1'b0; src_valid = 1'b0;
    step(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog [%s] actual=timeout expected=completion", phase);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule